// File: doc/BRIEF.md
# Delay Tap Sweep Calibrator

This block searches for a working read-capture delay for a memory interface. After a start pulse it walks a 6-bit delay tap upward from 0 to 63. For each tap value it drives that value onto every byte-lane tap output and starts an external memory self-test. It then waits for the self-test to report completion and decides from the returned status word whether the tap is good.

While the sweep runs, the block counts the good taps and remembers the lowest and the highest one. When the sweep finishes it loads the centre of that window into all lanes. If no tap was good it loads a fixed fallback value instead. It then pulses `done_o` for one cycle. The lane outputs keep the loaded value until the next sweep reprograms them. The self-test engine lives outside the block and is reached only through a start level and a status word.

Top module: `tap_sweep_cal`

## Requirements
- R1: After an accepted start, the block runs exactly 64 self-tests, one per tap value, in ascending order from 0 to 63.
- R2: Before each self-test start rises, every lane output (lane i in bits 6i+5:6i of `lane_taps_o`) carries the tap under test. The lane outputs stay unchanged while `bist_go_o` is high.
- R3: `bist_go_o` stays high until status bit 0 (done) is seen set. It then drops on the next clock edge. The pass-run count is read from status bits 8:1 and the fail-run count from bits 16:9.
- R4: A tap is good only when the fail-run count is zero and the pass-run count equals bits 8:1 of the `RUN_CFG` parameter (8 by default). A pass count of 7 or 9 with no fails, or 8 passes with any fail, marks the tap bad.
- R5: The block keeps only the lowest and the highest good tap. Bad taps lying between them do not change the window.
- R6: When at least one tap was good, every lane is loaded with (lowest + highest) >> 1, taken to 6 bits.
- R7: When no tap was good, every lane is loaded with 8 (`DEFAULT_TAP`).
- R8: `done_o` is high for exactly one cycle, with the final tap already present on the lanes. The lanes then hold that value while the block is idle.
- R9: A start pulse while a sweep is running is ignored. A start after completion begins a fresh sweep with the count and window cleared.
- R10: After reset, `lane_taps_o` is 0 and `bist_go_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a sweep when idle |
| done_o | output | 1 | One-cycle completion pulse |
| bist_go_o | output | 1 | Self-test start level |
| bist_stat_i | input | 17 | Self-test status: bit 0 done, 8:1 pass runs, 16:9 fail runs |
| lane_taps_o | output | 24 | Four 6-bit lane delay taps, lane 0 in the low bits |

## Verification
Fixed patterns cover the edge cases. With every tap bad, only the fallback can produce the result. With every tap good, the midpoint must be exactly 31. A single good tap at 63 tests the top edge of the window. A window split by bad taps shows that only the extremes are used. A map in which only one tap passes and every other tap is a near-miss (7 or 9 passes, or 8 passes with one fail) separates the exact pass rule from looser comparisons. Seeded random maps, with random self-test latency, then exercise general windows. A back-to-back all-bad run after a passing run exposes state carried over between sweeps. A start pulse injected mid-sweep shows whether a busy restart is refused.

// File: rtl/tapcal_pkg.sv
// Package: shared constants and state encoding for the tap sweep calibrator.
// Assumes a status word laid out as done | pass runs | fail runs from bit 0 up.
package tapcal_pkg;
    localparam int STAT_W   = 17;
    localparam int RCNT_W   = 8;
    localparam int DONE_BIT = 0;
    localparam int PASS_LSB = 1;
    localparam int FAIL_LSB = 9;
    localparam logic [31:0] NO_PASS_MARK = 32'hAA55_AA55;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_KICK,
        ST_WAIT,
        ST_JUDGE,
        ST_LOAD,
        ST_DONE
    } cal_state_e;
endpackage

// File: rtl/tap_sweep_fsm.sv
// Module: sequencer that steps the tap, drives the self-test and judges each result.
// Assumes the self-test keeps status bit 0 low until it restarts from a low go level.
module tap_sweep_fsm
    import tapcal_pkg::*;
#(
    parameter int          TAP_W   = 6,
    parameter logic [31:0] RUN_CFG = 32'h0000_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [TAP_W-1:0]  tap_o,
    output logic              bist_go_o,
    output logic              clear_o,
    output logic              load_sweep_o,
    output logic              load_final_o,
    output logic              judge_o,
    output logic              tap_good_o,
    output logic              done_o
);
    localparam logic [TAP_W-1:0]  TAP_LAST = {TAP_W{1'b1}};
    localparam logic [RCNT_W-1:0] RUN_CNT  = RUN_CFG[PASS_LSB +: RCNT_W];

    cal_state_e        state_q;
    logic [TAP_W-1:0]  tap_q;
    logic [RCNT_W-1:0] pass_q;
    logic [RCNT_W-1:0] fail_q;
    logic              go_q;

    // Sweep sequencing, self-test handshake and status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
            pass_q  <= '0;
            fail_q  <= '0;
            go_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        tap_q   <= '0;
                        state_q <= ST_PROG;
                    end
                end
                ST_PROG: state_q <= ST_KICK;
                ST_KICK: begin
                    go_q    <= 1'b1;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (stat_i[DONE_BIT]) begin
                        pass_q  <= stat_i[PASS_LSB +: RCNT_W];
                        fail_q  <= stat_i[FAIL_LSB +: RCNT_W];
                        go_q    <= 1'b0;
                        state_q <= ST_JUDGE;
                    end
                end
                ST_JUDGE: begin
                    if (tap_q == TAP_LAST) begin
                        state_q <= ST_LOAD;
                    end else begin
                        tap_q   <= tap_q + 1'b1;
                        state_q <= ST_PROG;
                    end
                end
                ST_LOAD: state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded control strobes and the per-tap verdict.
    always_comb begin
        clear_o      = (state_q == ST_IDLE) && start_i;
        load_sweep_o = (state_q == ST_PROG);
        load_final_o = (state_q == ST_LOAD);
        judge_o      = (state_q == ST_JUDGE);
        tap_good_o   = (fail_q == '0) && (pass_q == RUN_CNT);
        done_o       = (state_q == ST_DONE);
        tap_o        = tap_q;
        bist_go_o    = go_q;
    end

    assert_go_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && stat_i[DONE_BIT]) |=> !bist_go_o);
    assert_go_only_waiting_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bist_go_o |-> (state_q == ST_WAIT));
    assert_tap_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && tap_q != TAP_LAST) |=> (tap_q == $past(tap_q) + 1'b1));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && start_i && !stat_i[DONE_BIT]) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/pass_window.sv
// Module: tracks the good-tap count and window and forms the final tap.
// Assumes good taps arrive in ascending order within one sweep.
module pass_window
    import tapcal_pkg::*;
#(
    parameter int TAP_W       = 6,
    parameter int DEFAULT_TAP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             hit_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic [TAP_W-1:0] final_o
);
    localparam int CNT_W = TAP_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << TAP_W);

    logic [CNT_W-1:0] count_q;
    logic [31:0]      first_q;
    logic [TAP_W-1:0] last_q;
    logic             found;
    logic [TAP_W:0]   span_sum;

    assign found = (first_q != NO_PASS_MARK);

    // Good-tap counter and window capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_q <= '0;
            first_q <= NO_PASS_MARK;
            last_q  <= '0;
        end else if (hit_i) begin
            count_q <= count_q + 1'b1;
            last_q  <= tap_i;
            if (!found) first_q <= 32'(tap_i);
        end
    end

    // Window midpoint, or the fallback tap when nothing passed.
    always_comb begin
        span_sum = {1'b0, first_q[TAP_W-1:0]} + {1'b0, last_q};
        if (count_q == '0) final_o = TAP_W'(DEFAULT_TAP);
        else               final_o = span_sum[TAP_W:1];
    end

    assert_window_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (last_q >= first_q[TAP_W-1:0]));
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_MAX);
    assert_first_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !clear_i) |=> $stable(first_q));
endmodule

// File: rtl/lane_tap_bank.sv
// Module: one delay-tap register per byte lane, all loaded together.
// Assumes the loaded value is already final for the cycle of the load strobe.
module lane_tap_bank #(
    parameter int LANES = 4,
    parameter int TAP_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [TAP_W-1:0]       value_i,
    output logic [LANES*TAP_W-1:0] taps_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [TAP_W-1:0] tap_q;
        // Lane register: takes the shared value on a load strobe only.
        always_ff @(posedge clk) begin
            if (!rst_n)      tap_q <= '0;
            else if (load_i) tap_q <= value_i;
        end
        assign taps_o[g*TAP_W +: TAP_W] = tap_q;
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(taps_o));
endmodule

// File: rtl/tap_sweep_cal.sv
// Module: top of the delay tap sweep calibrator.
// Assumes an external self-test engine that answers each go level with one status word.
module tap_sweep_cal
    import tapcal_pkg::*;
#(
    parameter int          LANES       = 4,
    parameter int          TAP_W       = 6,
    parameter int          DEFAULT_TAP = 8,
    parameter logic [31:0] RUN_CFG     = 32'h0000_0010
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    output logic                   done_o,
    output logic                   bist_go_o,
    input  logic [STAT_W-1:0]      bist_stat_i,
    output logic [LANES*TAP_W-1:0] lane_taps_o
);
    logic [TAP_W-1:0] sweep_tap;
    logic [TAP_W-1:0] final_tap;
    logic [TAP_W-1:0] lane_value;
    logic clear, load_sweep, load_final, judge, tap_good;

    tap_sweep_fsm #(.TAP_W(TAP_W), .RUN_CFG(RUN_CFG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stat_i(bist_stat_i),
        .tap_o(sweep_tap), .bist_go_o(bist_go_o), .clear_o(clear),
        .load_sweep_o(load_sweep), .load_final_o(load_final),
        .judge_o(judge), .tap_good_o(tap_good), .done_o(done_o)
    );

    pass_window #(.TAP_W(TAP_W), .DEFAULT_TAP(DEFAULT_TAP)) u_window (
        .clk(clk), .rst_n(rst_n), .clear_i(clear),
        .hit_i(judge && tap_good), .tap_i(sweep_tap), .final_o(final_tap)
    );

    // Lane source: the tap under test, or the result at the end.
    always_comb lane_value = load_final ? final_tap : sweep_tap;

    lane_tap_bank #(.LANES(LANES), .TAP_W(TAP_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .load_i(load_sweep || load_final),
        .value_i(lane_value), .taps_o(lane_taps_o)
    );

    assert_lanes_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_go_o && $past(bist_go_o)) |-> $stable(lane_taps_o));
    assert_lane0_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bist_go_o) |-> (lane_taps_o[TAP_W-1:0] == sweep_tap));
endmodule

// File: tb/tap_sweep_cal_bench.sv
module tap_sweep_cal_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int TW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic done_o, bist_go_o;
    logic [16:0] bist_stat_i = '0;
    logic [NL*TW-1:0] lane_taps_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int runs = 0;
    logic go_prev = 1'b0;
    logic [7:0] pass_m [64];
    logic [7:0] fail_m [64];
    logic [63:0] good_map;
    int lat = 2;
    int bcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_sweep_cal u_tap_sweep_cal (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
        .bist_go_o(bist_go_o), .bist_stat_i(bist_stat_i), .lane_taps_o(lane_taps_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Self-test model: answers after a random latency, cleared while go is low.
    always @(posedge clk) begin
        if (!bist_go_o) begin
            bist_stat_i <= '0;
            bcnt <= 0;
            lat <= 1 + int'($urandom % 5);
        end else if (bcnt == lat) begin
            bist_stat_i <= {fail_m[lane_taps_o[TW-1:0]], pass_m[lane_taps_o[TW-1:0]], 1'b1};
        end else begin
            bcnt <= bcnt + 1;
        end
    end

    // Monitor on go rising: all lanes carry the next tap in sequence (R1, R2).
    always @(negedge clk) begin
        if (rst_n && bist_go_o && !go_prev) begin
            for (int l = 0; l < NL; l++)
                check(lane_taps_o[l*TW +: TW] == TW'(runs), "R2 lane tap at self-test start",
                      int'(lane_taps_o[l*TW +: TW]), runs);
            runs++;
        end
        go_prev <= bist_go_o;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic int expected_tap(input logic [63:0] m);
        int first = -1;
        int last = -1;
        for (int t = 0; t < 64; t++) if (m[t]) begin
            if (first < 0) first = t;
            last = t;
        end
        if (first < 0) return 8;
        return ((first + last) >> 1) & 63;
    endfunction

    // Fill the self-test map: good taps report 8 passes, bad ones a random near-miss (R4).
    task automatic set_map(input logic [63:0] m);
        good_map = m;
        for (int t = 0; t < 64; t++) begin
            if (m[t]) begin
                pass_m[t] = 8'd8; fail_m[t] = 8'd0;
            end else begin
                case ($urandom % 4)
                    0: begin pass_m[t] = 8'd7; fail_m[t] = 8'd0; end
                    1: begin pass_m[t] = 8'd9; fail_m[t] = 8'd0; end
                    2: begin pass_m[t] = 8'd8; fail_m[t] = 8'd1; end
                    default: begin pass_m[t] = 8'd0; fail_m[t] = 8'd8; end
                endcase
            end
        end
    endtask

    task automatic run_sweep(input bit poke, input string req);
        int exp_tap;
        int n;
        exp_tap = expected_tap(good_map);
        runs = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
            if (poke && n == 100) start_i = 1'b1;   // R9 busy restart attempt
            if (poke && n == 101) start_i = 1'b0;
        end
        check(done_o == 1'b1, "R8 done reached", int'(done_o), 1);
        check(runs == 64, "R1 self-test count", runs, 64);
        for (int l = 0; l < NL; l++)
            check(lane_taps_o[l*TW +: TW] == TW'(exp_tap), req, int'(lane_taps_o[l*TW +: TW]), exp_tap);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
        repeat (3) @(negedge clk);
        check(lane_taps_o[TW-1:0] == TW'(exp_tap), "R8 lanes hold", int'(lane_taps_o[TW-1:0]), exp_tap);
    endtask

    initial begin
        logic [63:0] m;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(lane_taps_o == '0, "R10 reset lanes", int'(lane_taps_o), 0);
        check(bist_go_o == 1'b0 && done_o == 1'b0, "R10 reset outputs", int'({bist_go_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        set_map(64'h0);
        run_sweep(1'b0, "R7 fallback tap");
        set_map({64{1'b1}});
        run_sweep(1'b0, "R6 full window midpoint");
        set_map(64'h8000_0000_0000_0000);
        run_sweep(1'b0, "R6 single top tap");
        m = '0; m[5] = 1'b1; m[6] = 1'b1; m[40] = 1'b1;
        set_map(m);
        run_sweep(1'b0, "R5 split window spans bad taps");
        m = '0; m[20] = 1'b1;
        set_map(m);
        run_sweep(1'b0, "R4 only exact pass counts");
        set_map({64{1'b1}});
        run_sweep(1'b0, "R6 before restart");
        set_map(64'h0);
        run_sweep(1'b0, "R9 fresh sweep clears window");
        m = '0; m[10] = 1'b1; m[50] = 1'b1;
        set_map(m);
        run_sweep(1'b1, "R9 busy start ignored");
        for (int k = 0; k < 6; k++) begin
            m = {$urandom, $urandom} & {$urandom, $urandom};
            set_map(m);
            run_sweep(1'b0, "R6 random window");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule